// File: doc/BRIEF.md
# Breakpoint Extended Value Access Arbiter

This block decides, in a single combinational step, what happens when a 32-bit coprocessor move instruction tries to read or write one of the extended value registers that hold virtual-machine or context identifiers for breakpoint matching. It takes the decoded instruction fields, the current privilege level, a set of implementation straps, and the trap-control state of the higher privilege levels. It returns exactly one outcome: perform the access, raise an undefined-instruction exception, trap to level 2 (64-bit), take a 32-bit hypervisor trap, trap to level 3, or enter debug halt.

The decision is a fixed priority chain. Its length depends on the privilege level: level 1 sees every check, level 2 skips the two level-2 trap checks, and level 3 only sees the external-debugger halt check. An instruction whose opcode fields do not name this register family raises a separate not-selected flag and no outcome. Reads and writes follow identical rules. The direction only steers which of two go strobes fires when the access proceeds.

Top module: `bkpt_xval_acc_arb`

## Requirements
- R1: The access is selected only when the coprocessor field is 4'b1110, op1 is 3'b000, CRn is 4'b0000 and op2 is 3'b001. Otherwise `not_sel` is 1 and `outcome`, `exc_class`, `rd_go` and `wr_go` are all 0.
- R2: A selected access whose CRm value is not below the parameter `NUM_BKPT` gives the undefined outcome (`outcome` bit 1) at any privilege level.
- R3: A selected, in-range access from level 0 gives the undefined outcome.
- R4: At level 1 the first matching check wins, in this order. (a) Level 3 is present, the undefined-priority strap is set, level 3 is 64-bit and its trap bit is 1: undefined. (b) Level 2 is enabled and 64-bit and either of its two trap bits is 1: trap to level 2 (bit 2). (c) Level 2 is enabled and 32-bit and either hypervisor trap bit is 1: hypervisor trap (bit 3). (d) Level 3 is present, 64-bit and its trap bit is 1: undefined if the secure-debug undefined strap is set, otherwise trap to level 3 (bit 4). (e) The OS lock is clear, halting is allowed and the external trap bit is 1: halt (bit 5). (f) Otherwise: access (bit 0).
- R5: At level 2 the chain of R4 applies with checks (b) and (c) removed.
- R6: At level 3 the outcome is halt when check (e) of R4 holds, and access otherwise.
- R7: `exc_class` is 6'h05 whenever the outcome is one of the three traps (bits 2, 3 or 4), and 6'h00 otherwise.
- R8: The direction input `is_write` has no effect on `outcome`. When the outcome is access, `wr_go` equals `is_write` and `rd_go` equals its inverse. Both go strobes are 0 for every other outcome.
- R9: When selected, exactly one bit of `outcome` is set. The bit order is access, undefined, trap-to-2, hypervisor trap, trap-to-3, halt, for bits 0 to 5.
- R10: `bp_index` always equals the CRm field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_cpnum | input | 4 | Coprocessor number field |
| f_op1 | input | 3 | First opcode field |
| f_crn | input | 4 | CRn field |
| f_crm | input | 4 | CRm field, breakpoint index |
| f_op2 | input | 3 | Second opcode field |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| has_l3 | input | 1 | Level 3 implemented |
| l2_enabled | input | 1 | Level 2 enabled in the current state |
| l2_is32 | input | 1 | Level 2 runs in 32-bit state |
| l3_is32 | input | 1 | Level 3 runs in 32-bit state |
| l3_undef_prio | input | 1 | Level-3 undefined condition takes top priority |
| l3_sdd_undef | input | 1 | Secure debug disabled turns a level-3 trap into undefined |
| l3_trap_bit | input | 1 | Level-3 debug trap control bit |
| l2_trap_bits | input | 2 | Level-2 (64-bit) debug trap control bits |
| hyp_trap_bits | input | 2 | Hypervisor (32-bit) debug trap control bits |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting is allowed |
| ext_trap | input | 1 | External debugger trap bit |
| not_sel | output | 1 | Instruction does not address this register family |
| outcome | output | 6 | One-hot decision, bit order as in R9 |
| exc_class | output | 6 | Exception class for trap outcomes |
| bp_index | output | 4 | Target breakpoint index |
| rd_go | output | 1 | Read proceeds |
| wr_go | output | 1 | Write proceeds |

## Verification
Every output is a pure function of the present inputs and has no register on its path, so each result is due in the same cycle as its stimulus. The bench drives a new input set on the falling clock edge and samples one time unit later, well clear of the rising edge. It sweeps every combination of privilege level, straps and trap bits for a selected in-range access, then applies random opcode fields and indices so that the not-selected and out-of-range paths are covered too.

// File: rtl/bxv_arb_pkg.sv
package bxv_arb_pkg;

  localparam int N_OUT = 6;

  typedef enum logic [2:0] {
    OC_ACCESS  = 3'd0,
    OC_UNDEF   = 3'd1,
    OC_TRAP_L2 = 3'd2,
    OC_HYP     = 3'd3,
    OC_TRAP_L3 = 3'd4,
    OC_HALT    = 3'd5
  } outcome_e;

  localparam logic [3:0] SEL_CP  = 4'b1110;
  localparam logic [2:0] SEL_OP1 = 3'b000;
  localparam logic [3:0] SEL_CRN = 4'b0000;
  localparam logic [2:0] SEL_OP2 = 3'b001;

  localparam logic [5:0] EC_DBG_TRAP = 6'h05;

  // Conditions in chain priority order (MSB first); l3_sdd_undef modifies l3_trap.
  typedef struct packed {
    logic l3_undef_first;
    logic l2_a64_trap;
    logic hyp_trap;
    logic l3_trap;
    logic l3_sdd_undef;
    logic halt;
  } cond_t;

  function automatic logic [N_OUT-1:0] oc_to_vec(input outcome_e oc);
    return N_OUT'(1) << oc;
  endfunction

  function automatic logic oc_is_trap(input outcome_e oc);
    return (oc == OC_TRAP_L2) || (oc == OC_HYP) || (oc == OC_TRAP_L3);
  endfunction

  // Which checks a level sees.
  function automatic cond_t level_mask(input int lvl);
    cond_t m;
    case (lvl)
      1:       m = 6'b111111;
      2:       m = 6'b100111;
      default: m = 6'b000001;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bxv_sel_decode.sv
module bxv_sel_decode
  import bxv_arb_pkg::*;
#(
  parameter int NUM_BKPT = 16
) (
  input  logic [3:0] cpnum,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       sel_hit,
  output logic       idx_ok
);
  always_comb begin
    sel_hit = (cpnum == SEL_CP) && (op1 == SEL_OP1) &&
              (crn == SEL_CRN) && (op2 == SEL_OP2);
    idx_ok  = int'(crm) < NUM_BKPT;
  end
endmodule

// File: rtl/bxv_cond_eval.sv
module bxv_cond_eval
  import bxv_arb_pkg::*;
(
  input  logic       has_l3,
  input  logic       l2_enabled,
  input  logic       l2_is32,
  input  logic       l3_is32,
  input  logic       l3_undef_prio,
  input  logic       l3_sdd_undef,
  input  logic       l3_trap_bit,
  input  logic [1:0] l2_trap_bits,
  input  logic [1:0] hyp_trap_bits,
  input  logic       os_lock,
  input  logic       halt_ok,
  input  logic       ext_trap,
  output cond_t      cond
);
  logic l3_a64_trap;

  always_comb begin
    l3_a64_trap          = has_l3 && !l3_is32 && l3_trap_bit;
    cond.l3_undef_first  = l3_a64_trap && l3_undef_prio;
    cond.l2_a64_trap     = l2_enabled && !l2_is32 && (l2_trap_bits != 2'b00);
    cond.hyp_trap        = l2_enabled && l2_is32 && (hyp_trap_bits != 2'b00);
    cond.l3_trap         = l3_a64_trap;
    cond.l3_sdd_undef    = l3_sdd_undef;
    cond.halt            = !os_lock && halt_ok && ext_trap;
  end
endmodule

// File: rtl/bxv_level_chain.sv
module bxv_level_chain
  import bxv_arb_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  cond_t    cond,
  output outcome_e res
);
  localparam cond_t MASK = level_mask(LEVEL);

  cond_t c;

  always_comb begin
    c = cond & MASK;
    if (c.l3_undef_first)   res = OC_UNDEF;
    else if (c.l2_a64_trap) res = OC_TRAP_L2;
    else if (c.hyp_trap)    res = OC_HYP;
    else if (c.l3_trap)     res = c.l3_sdd_undef ? OC_UNDEF : OC_TRAP_L3;
    else if (c.halt)        res = OC_HALT;
    else                    res = OC_ACCESS;
  end
endmodule

// File: rtl/bkpt_xval_acc_arb.sv
module bkpt_xval_acc_arb
  import bxv_arb_pkg::*;
#(
  parameter int NUM_BKPT = 16
) (
  input  logic [3:0] f_cpnum,
  input  logic [2:0] f_op1,
  input  logic [3:0] f_crn,
  input  logic [3:0] f_crm,
  input  logic [2:0] f_op2,
  input  logic       is_write,
  input  logic [1:0] cur_lvl,
  input  logic       has_l3,
  input  logic       l2_enabled,
  input  logic       l2_is32,
  input  logic       l3_is32,
  input  logic       l3_undef_prio,
  input  logic       l3_sdd_undef,
  input  logic       l3_trap_bit,
  input  logic [1:0] l2_trap_bits,
  input  logic [1:0] hyp_trap_bits,
  input  logic       os_lock,
  input  logic       halt_ok,
  input  logic       ext_trap,
  output logic       not_sel,
  output logic [5:0] outcome,
  output logic [5:0] exc_class,
  output logic [3:0] bp_index,
  output logic       rd_go,
  output logic       wr_go
);
  localparam int FIRST_LVL = 1;
  localparam int LAST_LVL  = 3;

  logic     sel_hit;
  logic     idx_ok;
  cond_t    cond;
  outcome_e lvl_res [LAST_LVL:FIRST_LVL];
  outcome_e chosen;
  logic     force_undef;

  bxv_sel_decode #(.NUM_BKPT(NUM_BKPT)) u_dec (
    .cpnum   (f_cpnum),
    .op1     (f_op1),
    .crn     (f_crn),
    .crm     (f_crm),
    .op2     (f_op2),
    .sel_hit (sel_hit),
    .idx_ok  (idx_ok)
  );

  bxv_cond_eval u_cond (
    .has_l3        (has_l3),
    .l2_enabled    (l2_enabled),
    .l2_is32       (l2_is32),
    .l3_is32       (l3_is32),
    .l3_undef_prio (l3_undef_prio),
    .l3_sdd_undef  (l3_sdd_undef),
    .l3_trap_bit   (l3_trap_bit),
    .l2_trap_bits  (l2_trap_bits),
    .hyp_trap_bits (hyp_trap_bits),
    .os_lock       (os_lock),
    .halt_ok       (halt_ok),
    .ext_trap      (ext_trap),
    .cond          (cond)
  );

  for (genvar lv = FIRST_LVL; lv <= LAST_LVL; lv++) begin : g_lvl
    bxv_level_chain #(.LEVEL(lv)) u_chain (
      .cond (cond),
      .res  (lvl_res[lv])
    );
  end

  always_comb begin
    force_undef = !idx_ok || (cur_lvl == 2'd0);
    chosen      = force_undef ? OC_UNDEF : lvl_res[cur_lvl == 2'd0 ? FIRST_LVL : int'(cur_lvl)];
    not_sel     = !sel_hit;
    outcome     = sel_hit ? oc_to_vec(chosen) : '0;
    exc_class   = (sel_hit && oc_is_trap(chosen)) ? EC_DBG_TRAP : 6'h00;
    rd_go       = sel_hit && (chosen == OC_ACCESS) && !is_write;
    wr_go       = sel_hit && (chosen == OC_ACCESS) && is_write;
    bp_index    = f_crm;
  end
endmodule

// File: rtl/bkpt_xval_acc_arb_chk.sv
module bkpt_xval_acc_arb_chk #(
  parameter int NUM_BKPT = 16
) (
  input logic       sel_hit,
  input logic       idx_ok,
  input logic [1:0] cur_lvl,
  input logic [3:0] f_crm,
  input logic       not_sel,
  input logic [5:0] outcome,
  input logic [5:0] exc_class,
  input logic [3:0] bp_index,
  input logic       rd_go,
  input logic       wr_go
);
  always_comb begin
    if (sel_hit) a_r9_one_outcome: assert ($onehot(outcome));
    if (!sel_hit) a_r1_quiet_unsel: assert (not_sel && outcome == 6'd0 && exc_class == 6'd0);
    if (sel_hit && !idx_ok) a_r2_range_undef: assert (outcome == 6'b000010);
    if (sel_hit && cur_lvl == 2'd0) a_r3_lvl0_undef: assert (outcome == 6'b000010);
    if (sel_hit && idx_ok && cur_lvl == 2'd3) a_r6_lvl3_limited: assert ((outcome & 6'b011110) == 6'd0);
    a_r7_class: assert ((exc_class == 6'h05) == ((outcome & 6'b011100) != 6'd0));
    a_r8_go_excl: assert (!(rd_go && wr_go) && ((rd_go || wr_go) == outcome[0]));
    a_r10_index: assert (bp_index == f_crm);
  end
endmodule

bind bkpt_xval_acc_arb bkpt_xval_acc_arb_chk #(.NUM_BKPT(NUM_BKPT)) u_chk (
  .sel_hit   (sel_hit),
  .idx_ok    (idx_ok),
  .cur_lvl   (cur_lvl),
  .f_crm     (f_crm),
  .not_sel   (not_sel),
  .outcome   (outcome),
  .exc_class (exc_class),
  .bp_index  (bp_index),
  .rd_go     (rd_go),
  .wr_go     (wr_go)
);

// File: tb/sim_bkpt_xval_acc_arb.sv
module sim_bkpt_xval_acc_arb;
  localparam int CLK_PER = 10;
  localparam int NB      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [3:0] f_cpnum, f_crn, f_crm;
  logic [2:0] f_op1, f_op2;
  logic       is_write, has_l3, l2_enabled, l2_is32, l3_is32;
  logic       l3_undef_prio, l3_sdd_undef, l3_trap_bit, os_lock, halt_ok, ext_trap;
  logic [1:0] cur_lvl, l2_trap_bits, hyp_trap_bits;
  logic       not_sel, rd_go, wr_go;
  logic [5:0] outcome, exc_class;
  logic [3:0] bp_index;

  int checks = 0;
  int errors = 0;

  bkpt_xval_acc_arb #(.NUM_BKPT(NB)) u0 (.*);

  // Model code: 0 access, 1 undef, 2 trap-2, 3 hyp, 4 trap-3, 5 halt, 7 not selected.
  function automatic int model_code();
    logic hc;
    hc = !os_lock && halt_ok && ext_trap;
    if (!(f_cpnum == 4'd14 && f_op1 == 3'd0 && f_crn == 4'd0 && f_op2 == 3'd1)) return 7;
    if (int'(f_crm) >= NB) return 1;
    if (cur_lvl == 2'd0) return 1;
    if (cur_lvl == 2'd3) return hc ? 5 : 0;
    if (has_l3 && l3_undef_prio && !l3_is32 && l3_trap_bit) return 1;
    if (cur_lvl == 2'd1) begin
      if (l2_enabled && !l2_is32 && l2_trap_bits != 2'b00) return 2;
      if (l2_enabled && l2_is32 && hyp_trap_bits != 2'b00) return 3;
    end
    if (has_l3 && !l3_is32 && l3_trap_bit) return l3_sdd_undef ? 1 : 4;
    return hc ? 5 : 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h lvl=%0d crm=%0d", req, act, exp, cur_lvl, f_crm);
    end
  endtask

  task automatic check_all(input string chain_req);
    int code;
    logic [5:0] ev;
    code = model_code();
    ev = (code == 7) ? 6'd0 : (6'd1 << code);
    chk("R1", {31'd0, not_sel}, {31'd0, code == 7});
    if (code != 7 && int'(f_crm) >= NB) chk("R2", {26'd0, outcome}, 32'h2);
    else chk(chain_req, {26'd0, outcome}, {26'd0, ev});
    chk("R7", {26'd0, exc_class}, (code >= 2 && code <= 4) ? 32'h5 : 32'h0);
    chk("R8", {30'd0, wr_go, rd_go}, (code == 0) ? (is_write ? 32'h2 : 32'h1) : 32'h0);
    if (code != 7) chk("R9", $countones(outcome), 1);
    chk("R10", {28'd0, bp_index}, {28'd0, f_crm});
  endtask

  function automatic string lvl_req();
    case (cur_lvl)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [5:0] oc_rd;
    void'($urandom(32'd1234));
    {f_cpnum, f_op1, f_crn, f_crm, f_op2, is_write, cur_lvl, has_l3, l2_enabled,
     l2_is32, l3_is32, l3_undef_prio, l3_sdd_undef, l3_trap_bit, l2_trap_bits,
     hyp_trap_bits, os_lock, halt_ok, ext_trap} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // Reset-state inputs are all zero: not selected, no outcome (R1).
    chk("R1", {26'd0, outcome}, 32'h0);
    chk("R1", {31'd0, not_sel}, 32'h1);

    // Directed: level-1 priority with every condition true gives undefined first (R4).
    @(negedge clk);
    f_cpnum = 4'd14; f_op2 = 3'd1; f_crm = 4'd2; cur_lvl = 2'd1;
    has_l3 = 1; l3_undef_prio = 1; l3_trap_bit = 1; l2_enabled = 1; l2_trap_bits = 2'b01;
    ext_trap = 1; halt_ok = 1;
    #1; chk("R4", {26'd0, outcome}, 32'h2);
    // Drop the top check: level-2 trap takes over (R4).
    @(negedge clk); l3_undef_prio = 0; #1;
    chk("R4", {26'd0, outcome}, 32'h4);
    // Same at level 2: skip level-2 trap, level-3 trap wins (R5).
    @(negedge clk); cur_lvl = 2'd2; #1;
    chk("R5", {26'd0, outcome}, 32'h10);
    // Level 3 sees only halt (R6).
    @(negedge clk); cur_lvl = 2'd3; #1;
    chk("R6", {26'd0, outcome}, 32'h20);
    // Boundary index NB-1 in range, NB out of range (R2).
    @(negedge clk); os_lock = 1; f_crm = 4'(NB - 1); is_write = 1; #1;
    chk("R8", {30'd0, wr_go, rd_go}, 32'h2);
    oc_rd = outcome;
    @(negedge clk); is_write = 0; #1;
    chk("R8", {26'd0, outcome}, {26'd0, oc_rd});
    @(negedge clk); f_crm = 4'(NB); #1;
    chk("R2", {26'd0, outcome}, 32'h2);

    // Exhaustive sweep of level, straps and trap bits for a selected in-range access.
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      f_cpnum = 4'd14; f_op1 = 3'd0; f_crn = 4'd0; f_op2 = 3'd1;
      cur_lvl       = v[1:0];
      has_l3        = v[2];
      l2_enabled    = v[3];
      l2_is32       = v[4];
      l3_is32       = v[5];
      l3_undef_prio = v[6];
      l3_sdd_undef  = v[7];
      l3_trap_bit   = v[8];
      l2_trap_bits  = v[10:9];
      hyp_trap_bits = v[12:11];
      os_lock       = v[13];
      halt_ok       = v[14];
      ext_trap      = v[15];
      f_crm         = 4'(v % NB);
      is_write      = v[0] ^ v[5] ^ v[9];
      #1;
      check_all(lvl_req());
    end

    // Random fields, including mismatching opcodes and out-of-range indices.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      f_cpnum = ($urandom % 2) ? 4'd14 : 4'($urandom);
      f_op1   = ($urandom % 4) ? 3'd0 : 3'($urandom);
      f_crn   = ($urandom % 4) ? 4'd0 : 4'($urandom);
      f_op2   = ($urandom % 4) ? 3'd1 : 3'($urandom);
      f_crm   = 4'($urandom);
      {is_write, cur_lvl, has_l3, l2_enabled, l2_is32, l3_is32, l3_undef_prio,
       l3_sdd_undef, l3_trap_bit, l2_trap_bits, hyp_trap_bits, os_lock, halt_ok,
       ext_trap} = 18'($urandom);
      #1;
      check_all(lvl_req());
    end

    finish_run();
  end
endmodule